// File: doc/BRIEF.md
# Interleaved CBC Chaining Controller

This block lets a fixed-latency, fully pipelined 64-bit block cipher run chained (CBC-style) encryption without stalling. In ordinary CBC each block must wait for its predecessor's ciphertext, so a deep cipher pipeline stays mostly empty. This controller instead assigns incoming blocks round-robin to `N_WAYS` independent chains. Block number i of a message goes to chain `i mod N_WAYS`. Each chain XORs its plaintext with the most recent ciphertext of that same chain. The first block of each chain uses a per-chain initial value instead.

The cipher core sits outside the block, behind an issue/return port pair. It must return each result exactly `N_WAYS` cycles after issue. With that latency, the ciphertext a chain needs comes back in the very cycle its next block is accepted, so one block can enter every cycle. Ciphertext leaves in arrival order on a valid/ready output. A small result buffer absorbs output stalls, and input ready is withdrawn once every buffer slot is spoken for.

Software loads the initial values while the block is idle. A start pulse opens a message and an end pulse closes it. The end pulse drains all work in flight and restores every chain to its initial value. With `N_WAYS = 1` the block is plain CBC.

Top module: `icbc_ctrl`

## Requirements
- R1: After reset the block is idle. `in_ready_o`, `out_valid_o` and `cph_vld_o` are all 0 until a start pulse arrives.
- R2: For a message with blocks P0, P1, ..., block i belongs to chain w = i mod N_WAYS. Its ciphertext is E(Pi XOR X), where X is the ciphertext of block i−N_WAYS, or the initial value of chain w when i < N_WAYS.
- R3: With N_WAYS = 1 the output is standard CBC under a single initial value (index 0), and input is still accepted every cycle when output is never stalled.
- R4: While running, with `in_valid_i` held high and `out_ready_i` held high, one block is accepted in every cycle.
- R5: With no output stall, ciphertext for a block accepted at clock edge E is shown on `out_valid_o`/`out_data_o` after edge E+N_WAYS−1, that is, N_WAYS edges counting E. Outputs appear in acceptance order. A shown output that is not taken stays valid with unchanged data in the next cycle. The core's `cph_vld_i` must follow issue by exactly N_WAYS cycles.
- R6: Blocks accepted but not yet delivered never exceed N_WAYS. `in_ready_o` is withdrawn as needed under output stalls, and no block is lost or duplicated.
- R7: Writes on the initial-value port (`cfg_we_i`, index `cfg_idx_i`) take effect only while idle. Writes made during a message do not alter any later message.
- R8: A `msg_end_i` pulse while running closes the message. `in_ready_o` is 0 from then until every outstanding block has been delivered, after which the block is idle. The next start resumes at chain 0 with every chain equal to its initial value.
- R9: `cph_vld_o` is high exactly in cycles where an input block is accepted. `cph_dat_o` is then the input block XOR the current chain value of its chain, so the first block of a message is issued as P0 XOR initial value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a message (taken while idle) |
| msg_end_i | input | 1 | Closes the current message and drains it |
| cfg_we_i | input | 1 | Initial-value write strobe (idle only) |
| cfg_idx_i | input | WAY_W | Chain index for the initial-value write |
| cfg_iv_i | input | 64 | Initial value to write |
| in_valid_i | input | 1 | Plaintext block valid |
| in_ready_o | output | 1 | Plaintext block can be taken |
| in_data_i | input | 64 | Plaintext block |
| out_valid_o | output | 1 | Ciphertext block valid |
| out_ready_i | input | 1 | Downstream takes ciphertext |
| out_data_o | output | 64 | Ciphertext block |
| cph_vld_o | output | 1 | Issue strobe to the cipher core |
| cph_dat_o | output | 64 | Chained block issued to the cipher core |
| cph_vld_i | input | 1 | Result strobe from the cipher core |
| cph_dat_i | input | 64 | Result from the cipher core |

## Verification
Embedded assertions check the following on every cycle:
- the core's return strobe lines up with the controller's own record of issued blocks;
- the chain pointer advances by one, modulo the chain count, on each acceptance;
- outstanding work never exceeds N_WAYS and the result buffer never overflows;
- a stalled output keeps its data;
- the idle state holds nothing in flight;
- a drained message returns to idle.

Only the bench scenarios can show the remaining behaviours. These are the actual ciphertext values under interleaved chaining, the single-chain CBC case, full-rate acceptance, the exact output latency, and that initial-value writes made mid-message have no lasting effect. The bench also shows that a second message starts afresh from the initial values.

// File: rtl/icbc_pkg.sv
package icbc_pkg;
    localparam int BLK_W = 64;
    typedef logic [BLK_W-1:0] blk_t;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/icbc_tag_pipe.sv
// Shadow of the cipher pipeline: one valid bit and chain index per stage.
module icbc_tag_pipe
    import icbc_pkg::*;
#(
    parameter int N_WAYS = 3,
    parameter int WAY_W  = 2,
    parameter int OCC_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WAY_W-1:0] push_way,
    output logic             exit_vld,
    output logic [WAY_W-1:0] exit_way,
    output logic [OCC_W-1:0] occ
);
    typedef struct packed {
        logic [N_WAYS-1:0]            vld;
        logic [N_WAYS-1:0][WAY_W-1:0] way;
    } tp_t;

    tp_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.vld[0] = push;
        s_d.way[0] = push_way;
        for (int k = 1; k < N_WAYS; k++) begin
            s_d.vld[k] = s_q.vld[k-1];
            s_d.way[k] = s_q.way[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign exit_vld = s_q.vld[N_WAYS-1];
    assign exit_way = s_q.way[N_WAYS-1];
    assign occ      = OCC_W'($countones(s_q.vld));
endmodule

// File: rtl/icbc_chain_bank.sv
// Per-chain initial values and chaining registers, with same-cycle bypass.
module icbc_chain_bank
    import icbc_pkg::*;
#(
    parameter int N_WAYS = 3,
    parameter int WAY_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iv_we,
    input  logic [WAY_W-1:0] iv_idx,
    input  blk_t             iv_val,
    input  logic             reload,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    input  blk_t             upd_val,
    input  logic [WAY_W-1:0] rd_way,
    output blk_t             rd_val
);
    typedef struct packed {
        blk_t [N_WAYS-1:0] iv;
        blk_t [N_WAYS-1:0] ch;
    } cb_t;

    cb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < N_WAYS; k++) begin
            if (iv_we && iv_idx == WAY_W'(k)) s_d.iv[k] = iv_val;
            if (reload)                           s_d.ch[k] = s_q.iv[k];
            else if (upd_en && upd_way == WAY_W'(k)) s_d.ch[k] = upd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // A returning result for the chain being read is forwarded directly.
    assign rd_val = (upd_en && upd_way == rd_way) ? upd_val : s_q.ch[rd_way];
endmodule

// File: rtl/icbc_out_fifo.sv
// Result buffer that absorbs ciphertext while the output is stalled.
module icbc_out_fifo
    import icbc_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  blk_t             din,
    input  logic             pop,
    output blk_t             dout,
    output logic [CNT_W-1:0] cnt,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        blk_t [DEPTH-1:0] mem;
        logic [PW-1:0]    wp;
        logic [PW-1:0]    rp;
        logic [CNT_W-1:0] cnt;
    } ff_t;

    ff_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = din;
            s_d.wp = (s_q.wp == PW'(DEPTH-1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) s_d.rp = (s_q.rp == PW'(DEPTH-1)) ? '0 : s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.mem[s_q.rp];
    assign cnt   = s_q.cnt;
    assign empty = (s_q.cnt == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (s_q.cnt < CNT_W'(DEPTH)));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/icbc_ctrl.sv
module icbc_ctrl
    import icbc_pkg::*;
#(
    parameter  int N_WAYS = 3,
    localparam int WAY_W  = (N_WAYS > 1) ? $clog2(N_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             msg_end_i,
    input  logic             cfg_we_i,
    input  logic [WAY_W-1:0] cfg_idx_i,
    input  logic [63:0]      cfg_iv_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [63:0]      in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [63:0]      out_data_o,
    output logic             cph_vld_o,
    output logic [63:0]      cph_dat_o,
    input  logic             cph_vld_i,
    input  logic [63:0]      cph_dat_i
);
    localparam int OCC_W = $clog2(N_WAYS + 1);
    localparam int SUM_W = $clog2(2 * N_WAYS + 1);

    typedef struct packed {
        ctl_st_e          st;
        logic [WAY_W-1:0] ptr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             exit_vld;
    logic [WAY_W-1:0] exit_way;
    logic [OCC_W-1:0] pipe_occ;
    logic [OCC_W-1:0] buf_cnt;
    logic             buf_empty;
    blk_t             buf_dout;
    blk_t             chain_val;
    logic             buf_push, buf_pop, out_fire, accept, reload;
    logic [SUM_W-1:0] occ_sum;

    // Outstanding work = blocks inside the cipher plus blocks parked in the buffer.
    assign occ_sum   = SUM_W'(pipe_occ) + SUM_W'(buf_cnt);
    assign out_valid_o = !buf_empty || exit_vld;
    assign out_data_o  = buf_empty ? cph_dat_i : buf_dout;
    assign out_fire  = out_valid_o && out_ready_i;
    assign buf_pop   = !buf_empty && out_ready_i;
    assign buf_push  = exit_vld && !(buf_empty && out_ready_i);

    always_comb begin
        c_d        = c_q;
        reload     = 1'b0;
        in_ready_o = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st  = ST_RUN;
                    c_d.ptr = '0;
                    reload  = 1'b1;
                end
            end
            ST_RUN: begin
                in_ready_o = !msg_end_i &&
                             (occ_sum < SUM_W'(N_WAYS) + SUM_W'(out_fire));
                if (msg_end_i) c_d.st = ST_DRAIN;
                else if (in_valid_i && in_ready_o)
                    c_d.ptr = (c_q.ptr == WAY_W'(N_WAYS-1)) ? '0 : c_q.ptr + 1'b1;
            end
            ST_DRAIN: begin
                if (occ_sum == '0) begin
                    c_d.st  = ST_IDLE;
                    c_d.ptr = '0;
                    reload  = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, ptr: '0};
        else        c_q <= c_d;
    end

    assign accept    = in_valid_i && in_ready_o;
    assign cph_vld_o = accept;
    assign cph_dat_o = in_data_i ^ chain_val;

    icbc_tag_pipe #(.N_WAYS(N_WAYS), .WAY_W(WAY_W), .OCC_W(OCC_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_way (c_q.ptr),
        .exit_vld (exit_vld),
        .exit_way (exit_way),
        .occ      (pipe_occ)
    );

    icbc_chain_bank #(.N_WAYS(N_WAYS), .WAY_W(WAY_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .iv_we   (cfg_we_i && c_q.st == ST_IDLE),
        .iv_idx  (cfg_idx_i),
        .iv_val  (cfg_iv_i),
        .reload  (reload),
        .upd_en  (exit_vld),
        .upd_way (exit_way),
        .upd_val (cph_dat_i),
        .rd_way  (c_q.ptr),
        .rd_val  (chain_val)
    );

    icbc_out_fifo #(.DEPTH(N_WAYS), .CNT_W(OCC_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (buf_push),
        .din   (cph_dat_i),
        .pop   (buf_pop),
        .dout  (buf_dout),
        .cnt   (buf_cnt),
        .empty (buf_empty)
    );

    // R5: the external core must answer exactly N_WAYS cycles after issue.
    p_core_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cph_vld_i == exit_vld);
    // R5: a stalled output keeps its value.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
    // R2: round-robin chain selection.
    p_rr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (c_q.ptr == ((N_WAYS == 1) ? '0 :
                    (($past(c_q.ptr) == WAY_W'(N_WAYS-1)) ? '0 : $past(c_q.ptr) + 1'b1))));
    // R6: outstanding work is bounded by the chain count.
    p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ_sum <= SUM_W'(N_WAYS));
    // R1: idle means nothing is in flight.
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE) |-> (occ_sum == '0));
    // R8: a drained message returns to idle.
    p_drain_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DRAIN && occ_sum == '0) |=> (c_q.st == ST_IDLE));
endmodule

// File: tb/tb_icbc_ctrl.sv
`timescale 1ns/1ps

// Stand-in cipher: keyed rotate-and-XOR, delayed LAT cycles.
module tb_cipher_stub #(
    parameter int          LAT = 3,
    parameter logic [63:0] KEY = 64'h0F1E2D3C4B5A6978
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vi,
    input  logic [63:0] di,
    output logic        vo,
    output logic [63:0] dout
);
    logic [LAT-1:0]       v_q;
    logic [LAT-1:0][63:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            d_q <= '0;
        end else begin
            v_q[0] <= vi;
            d_q[0] <= {di[50:0], di[63:51]} ^ KEY;
            for (int k = 1; k < LAT; k++) begin
                v_q[k] <= v_q[k-1];
                d_q[k] <= d_q[k-1];
            end
        end
    end
    assign vo   = v_q[LAT-1];
    assign dout = d_q[LAT-1];
endmodule

module tb_icbc_ctrl;
    localparam int          NW  = 3;
    localparam logic [63:0] KEY = 64'h0F1E2D3C4B5A6978;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // main instance (3 chains)
    logic        start = 0, msg_end = 0, cfg_we = 0, in_valid = 0, out_ready = 1;
    logic [1:0]  cfg_idx = 0;
    logic [63:0] cfg_iv = 0, in_data = 0;
    logic        in_ready, out_valid, cv_o, cv_i;
    logic [63:0] out_data, cd_o, cd_i;

    icbc_ctrl #(.N_WAYS(NW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .msg_end_i(msg_end),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_iv_i(cfg_iv),
        .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
        .cph_vld_o(cv_o), .cph_dat_o(cd_o), .cph_vld_i(cv_i), .cph_dat_i(cd_i));
    tb_cipher_stub #(.LAT(NW), .KEY(KEY)) u_core (
        .clk(clk), .rst_n(rst_n), .vi(cv_o), .di(cd_o), .vo(cv_i), .dout(cd_i));

    // single-chain instance
    logic        c_start = 0, c_end = 0, c_we = 0, c_valid = 0;
    logic [0:0]  c_idx = 0;
    logic [63:0] c_iv = 0, c_data = 0;
    logic        c_ready, c_ovalid, c_cvo, c_cvi;
    logic [63:0] c_odata, c_cdo, c_cdi;

    icbc_ctrl #(.N_WAYS(1)) dut_cbc (
        .clk(clk), .rst_n(rst_n), .start_i(c_start), .msg_end_i(c_end),
        .cfg_we_i(c_we), .cfg_idx_i(c_idx), .cfg_iv_i(c_iv),
        .in_valid_i(c_valid), .in_ready_o(c_ready), .in_data_i(c_data),
        .out_valid_o(c_ovalid), .out_ready_i(1'b1), .out_data_o(c_odata),
        .cph_vld_o(c_cvo), .cph_dat_o(c_cdo), .cph_vld_i(c_cvi), .cph_dat_i(c_cdi));
    tb_cipher_stub #(.LAT(1), .KEY(KEY)) u_core1 (
        .clk(clk), .rst_n(rst_n), .vi(c_cvo), .di(c_cdo), .vo(c_cvi), .dout(c_cdi));

    int total = 0, bad = 0;
    int gotn = 0, accn = 0, ovf_err = 0, c_gotn = 0;
    int blocked = 0, last_cyc = 0;
    logic [63:0] got [0:63];
    logic [63:0] c_got [0:15];
    logic [63:0] iv_ref [0:NW-1];
    logic [15:0] lf = 16'hACE1;

    // Output monitors: reads pre-edge values at the edge where the handshake completes.
    always @(posedge clk) begin
        if (in_valid && in_ready) accn = accn + 1;
        if (out_valid && out_ready) begin
            if (gotn < 64) got[gotn] = out_data;
            gotn = gotn + 1;
        end
        if (accn - gotn > NW) ovf_err = ovf_err + 1;
        if (c_ovalid) begin
            if (c_gotn < 16) c_got[c_gotn] = c_odata;
            c_gotn = c_gotn + 1;
        end
    end

    function automatic logic [63:0] enc(input logic [63:0] x);
        return {x[50:0], x[63:51]} ^ KEY;
    endfunction

    function automatic logic [63:0] pt(input int seed, input int i);
        return {32'(i) * 32'h9E3779B9 ^ 32'(seed), 32'hA5A50000 ^ 32'(i * 7 + seed)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic load_ivs(input int seed);
        for (int w = 0; w < NW; w++) begin
            @(negedge clk);
            iv_ref[w] = {32'(seed) ^ 32'h13579BDF, 32'(w) * 32'h01010101 ^ 32'hC0FFEE00};
            cfg_we = 1; cfg_idx = 2'(w); cfg_iv = iv_ref[w];
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wait_drain(input int n, input bit bp);
        int guard = 0;
        while (gotn < n && guard < 2000) begin
            step_lf();
            out_ready = bp ? lf[0] : 1'b1;
            @(negedge clk);
            guard++;
        end
        out_ready = 1;
        repeat (3) @(negedge clk);
    endtask

    // One message: drive n blocks, optional input gaps, output stalls, mid-message IV write.
    task automatic run_msg(input int n, input int seed, input bit gaps, input bit bp,
                           input bit poke, input string req);
        logic [63:0] ch [0:NW-1];
        logic [63:0] e;
        int i = 0;
        int cyc = 0;
        gotn = 0; accn = 0; blocked = 0;
        @(negedge clk);
        start = 1; out_ready = 1;
        @(negedge clk);
        start = 0;
        while (i < n && cyc < 2000) begin
            step_lf();
            out_ready = bp ? lf[0] : 1'b1;
            in_valid  = gaps ? lf[3] : 1'b1;
            in_data   = pt(seed, i);
            if (poke && i == 2) begin
                cfg_we = 1; cfg_idx = 2'd1; cfg_iv = 64'hDEAD_BEEF_0BAD_F00D;
            end
            #1;
            if (in_valid && in_ready) i++;
            else if (in_valid) blocked++;
            @(negedge clk);
            cyc++;
            in_valid = 0; cfg_we = 0;
        end
        last_cyc = cyc;
        msg_end = 1;
        @(negedge clk);
        msg_end = 0;
        // R8: draining state refuses input
        in_valid = 1; in_data = '1;
        #1;
        chk(in_ready == 1'b0, "R8 ready during drain", 64'(in_ready), 64'd0);
        @(negedge clk);
        in_valid = 0;
        wait_drain(n, bp);
        chk(gotn == n, {req, " count"}, 64'(gotn), 64'(n));
        for (int w = 0; w < NW; w++) ch[w] = iv_ref[w];
        for (int k = 0; k < n && k < 64; k++) begin
            e = enc(pt(seed, k) ^ ch[k % NW]);
            ch[k % NW] = e;
            chk(got[k] === e, req, got[k], e);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 0, "R1 in_ready idle", 64'(in_ready), 0);
        chk(out_valid == 0, "R1 out_valid idle", 64'(out_valid), 0);
        chk(cv_o == 0, "R1 cph_vld idle", 64'(cv_o), 0);
        chk(c_ready == 0 && c_ovalid == 0, "R1 single-chain idle", 64'({c_ready, c_ovalid}), 0);
        in_valid = 1; in_data = 64'h1234;
        #1;
        chk(in_ready == 0 && cv_o == 0, "R1 no accept before start", 64'({in_ready, cv_o}), 0);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic t_latency();
        logic [63:0] p;
        p = pt(99, 0);
        gotn = 0; accn = 0;
        @(negedge clk); start = 1; out_ready = 1;
        @(negedge clk); start = 0;
        in_valid = 1; in_data = p;
        #1;
        chk(in_ready == 1, "R9 ready on first block", 64'(in_ready), 1);
        chk(cv_o == 1 && cd_o == (p ^ iv_ref[0]), "R9 issue data", cd_o, p ^ iv_ref[0]);
        for (int k = 1; k <= NW; k++) begin
            @(negedge clk);
            in_valid = 0;
            #1;
            chk(out_valid == (k == NW), "R5 latency", 64'(out_valid), 64'(k == NW));
            if (k < NW) chk(cv_o == 0, "R9 no issue without accept", 64'(cv_o), 0);
        end
        chk(out_data == enc(p ^ iv_ref[0]), "R5 first output", out_data, enc(p ^ iv_ref[0]));
        msg_end = 1;
        @(negedge clk);
        msg_end = 0;
        wait_drain(1, 0);
    endtask

    task automatic t_stream();
        run_msg(12, 5, 0, 0, 0, "R2 stream");
        chk(last_cyc == 12, "R4 one block per cycle", 64'(last_cyc), 64'd12);
        chk(blocked == 0, "R4 no refusals", 64'(blocked), 0);
    endtask

    task automatic t_backpressure();
        ovf_err = 0;
        run_msg(40, 17, 1, 1, 0, "R6 stalled stream");
        chk(ovf_err == 0, "R6 outstanding bound", 64'(ovf_err), 0);
        chk(blocked > 0, "R6 ready withdrawn", 64'(blocked), 64'd1);
    endtask

    task automatic t_iv_lock();
        run_msg(7, 23, 0, 0, 1, "R7 message with write");
        run_msg(6, 31, 0, 0, 0, "R7 next message unchanged");
    endtask

    task automatic t_restart();
        run_msg(5, 41, 0, 0, 0, "R8 short message");
        run_msg(4, 43, 1, 0, 0, "R8 restart at chain 0");
    endtask

    task automatic t_cbc();
        logic [63:0] ivc, ch, e;
        int acc = 0;
        ivc = 64'h0123_4567_89AB_CDEF;
        c_gotn = 0;
        @(negedge clk); c_we = 1; c_idx = 0; c_iv = ivc;
        @(negedge clk); c_we = 0; c_start = 1;
        @(negedge clk); c_start = 0;
        for (int k = 0; k < 8; k++) begin
            c_valid = 1; c_data = pt(77, k);
            #1;
            if (c_ready) acc++;
            @(negedge clk);
        end
        c_valid = 0;
        chk(acc == 8, "R3 full rate single chain", 64'(acc), 64'd8);
        c_end = 1;
        @(negedge clk);
        c_end = 0;
        repeat (4) @(negedge clk);
        chk(c_gotn == 8, "R3 count", 64'(c_gotn), 64'd8);
        ch = ivc;
        for (int k = 0; k < 8; k++) begin
            e = enc(pt(77, k) ^ ch);
            ch = e;
            chk(c_got[k] === e, "R3 plain chaining", c_got[k], e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        load_ivs(1);
        t_latency();
        t_stream();
        t_backpressure();
        t_iv_lock();
        load_ivs(2);
        t_restart();
        t_cbc();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule